// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-node agent for a small distributed shared-memory machine with three processors. For every memory block it homes, it keeps a directory entry holding a coherence state and a presence vector with one bit per processor. It also keeps the backing data for each block.

Processors send the block three kinds of request:

- a read miss;
- a write miss;
- a write-back that flushes an owned line.

For each request the controller decides whether memory can answer directly. If not, it first sends coherence messages to other caches and waits for their answers. It then updates the entry and memory and replies to the requester with the block's data. Requests are served strictly one at a time.

The controller reports two kinds of recall. A switch-to-shared message downgrades an owner. A take-away message removes ownership. In both cases the owner's dirty data comes back on the acknowledge channel and is written to memory before the reply goes out. An invalidate message clears every other sharer before a write is granted. A lookup port shows the directory entry and the stored data for any chosen block.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every entry is Uncached (state code 0) with an empty presence vector, every stored word is zero, and `req_ready` is high.
- R2: A read miss to an Uncached (0) or Shared (1) block leaves it Shared with the requester's presence bit added to the existing ones. The reply carries the stored word, and no message is sent.
- R3: A read miss to an Exclusive (2) block held by another processor sends one message of kind 2 (switch to shared), addressed to the owner only. The owner's returned word is written to memory and replied. The entry becomes Shared with both the old owner and the requester present.
- R4: A write miss to a Shared block that has other sharers sends one message of kind 1 (invalidate), whose vector is every sharer except the requester. After all of those sharers acknowledge, the entry becomes Exclusive with only the writer present, and the stored word is replied.
- R5: A write miss from the only sharer of a Shared block sends no message. The entry becomes Exclusive with that one bit, and the stored word is replied.
- R6: A write miss to an Exclusive block held by another processor sends one message of kind 3 (take away), addressed to the owner only. The owner's word is stored and replied, and the entry becomes Exclusive with only the writer present.
- R7: A write miss to an Uncached block makes the entry Exclusive with only the writer present and replies the stored word without messages.
- R8: A write-back (request kind 2) from the Exclusive owner stores its data and returns the entry to Uncached with an empty vector. A write-back from any other processor, or to a non-Exclusive block, changes neither the entry nor memory, and produces no reply.
- R9: `req_ready` drops in the cycle after a request is accepted and stays low until that request completes. A reply and a message are never issued in the same cycle.
- R10: An Exclusive entry always has exactly one presence bit set, an Uncached entry has none, and a Shared entry has at least one.

Request kinds: 0 = read miss, 1 = write miss, 2 = write-back. Processor n's presence bit is bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | 2 | Requesting processor |
| req_blk | input | 3 | Block index |
| req_wdata | input | 16 | Write-back data |
| msg_valid | output | 1 | One-cycle coherence message pulse |
| msg_kind | output | 2 | 1 invalidate, 2 switch to shared, 3 take away |
| msg_vec | output | 3 | Destination processors, one bit each |
| msg_blk | output | 3 | Block the message concerns |
| ack_valid | input | 1 | Acknowledge from a processor |
| ack_src | input | 2 | Acknowledging processor |
| ack_data | input | 16 | Owner's data returned with a recall acknowledge |
| rsp_valid | output | 1 | One-cycle data reply pulse |
| rsp_dst | output | 2 | Processor receiving the reply |
| rsp_data | output | 16 | Block data |
| peek_blk | input | 3 | Block selected for lookup |
| peek_state | output | 2 | Directory state of the looked-up block |
| peek_vec | output | 3 | Presence vector of the looked-up block |
| peek_data | output | 16 | Stored word of the looked-up block |

## Verification
A directed sequence first walks one block through each transition:

- Uncached to Shared by two readers;
- Shared to Exclusive, invalidating two other sharers;
- the silent upgrade by a sole sharer;
- a take-away by a second writer;
- a downgrade by a reader;
- owner and non-owner write-backs.

Each of these separates one message kind, vector and final entry from the others. A seeded random stream of 200 mixed requests then follows, over all blocks and processors. Write-backs are biased toward the true owner, so that both the flush and the ignored case recur. In this stream, memory values that only a recalled owner holds show whether the returned data, rather than the stale stored word, reached memory and the reply.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {DS_U = 2'd0, DS_S = 2'd1, DS_E = 2'd2} dstate_t;
    typedef enum logic [1:0] {RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_WB = 2'd2, RQ_NONE = 2'd3} rkind_t;
    typedef enum logic [1:0] {MK_NONE = 2'd0, MK_INV = 2'd1, MK_SHR = 2'd2, MK_TAKE = 2'd3} mkind_t;
    typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WINV, ST_WOWN} fsm_t;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int NPROC = 3,
    parameter int DW    = 16,
    localparam int AW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    a_blk,
    output dstate_t          a_state,
    output logic [NPROC-1:0] a_vec,
    output logic [DW-1:0]    a_data,
    input  logic [AW-1:0]    b_blk,
    output dstate_t          b_state,
    output logic [NPROC-1:0] b_vec,
    output logic [DW-1:0]    b_data,
    input  logic             dir_we,
    input  dstate_t          dir_state_w,
    input  logic [NPROC-1:0] dir_vec_w,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_w
);
    dstate_t          st_q  [NBLK];
    logic [NPROC-1:0] vec_q [NBLK];
    logic [DW-1:0]    mem_q [NBLK];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) begin
                st_q[i]  <= DS_U;
                vec_q[i] <= '0;
                mem_q[i] <= '0;
            end
        end else begin
            if (dir_we) begin
                st_q[a_blk]  <= dir_state_w;
                vec_q[a_blk] <= dir_vec_w;
            end
            if (mem_we) mem_q[a_blk] <= mem_w;
        end
    end

    assign a_state = st_q[a_blk];
    assign a_vec   = vec_q[a_blk];
    assign a_data  = mem_q[a_blk];
    assign b_state = st_q[b_blk];
    assign b_vec   = vec_q[b_blk];
    assign b_data  = mem_q[b_blk];
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int NPROC = 3,
    parameter int DW    = 16,
    localparam int AW   = $clog2(NBLK),
    localparam int SW   = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [SW-1:0]    req_src,
    input  logic [AW-1:0]    req_blk,
    input  logic [DW-1:0]    req_wdata,
    output logic             msg_valid,
    output logic [1:0]       msg_kind,
    output logic [NPROC-1:0] msg_vec,
    output logic [AW-1:0]    msg_blk,
    input  logic             ack_valid,
    input  logic [SW-1:0]    ack_src,
    input  logic [DW-1:0]    ack_data,
    output logic             rsp_valid,
    output logic [SW-1:0]    rsp_dst,
    output logic [DW-1:0]    rsp_data,
    input  logic [AW-1:0]    peek_blk,
    output logic [1:0]       peek_state,
    output logic [NPROC-1:0] peek_vec,
    output logic [DW-1:0]    peek_data
);
    typedef struct packed {
        fsm_t             st;
        rkind_t           kind;
        logic [SW-1:0]    src;
        logic [AW-1:0]    blk;
        logic [DW-1:0]    wdata;
        logic [NPROC-1:0] pend;
        logic             rsp_v;
        logic [SW-1:0]    rsp_dst;
        logic [DW-1:0]    rsp_data;
        logic             msg_v;
        mkind_t           msg_kind;
        logic [NPROC-1:0] msg_vec;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    dstate_t          a_state, b_state, dir_state_w;
    logic [NPROC-1:0] a_vec, dir_vec_w, src_bit, others, pend_left;
    logic [DW-1:0]    a_data, mem_w;
    logic             dir_we, mem_we;

    coh_dir_store #(.NBLK(NBLK), .NPROC(NPROC), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_blk(ctl_q.blk), .a_state(a_state), .a_vec(a_vec), .a_data(a_data),
        .b_blk(peek_blk), .b_state(b_state), .b_vec(peek_vec), .b_data(peek_data),
        .dir_we(dir_we), .dir_state_w(dir_state_w), .dir_vec_w(dir_vec_w),
        .mem_we(mem_we), .mem_w(mem_w)
    );

    assign src_bit = NPROC'(1) << ctl_q.src;
    assign others  = a_vec & ~src_bit;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rsp_v    = 1'b0;
        ctl_d.msg_v    = 1'b0;
        dir_we         = 1'b0;
        dir_state_w    = DS_U;
        dir_vec_w      = '0;
        mem_we         = 1'b0;
        mem_w          = '0;
        pend_left      = ctl_q.pend;
        case (ctl_q.st)
            ST_IDLE: if (req_valid) begin
                ctl_d.st    = ST_EXEC;
                ctl_d.kind  = rkind_t'(req_kind);
                ctl_d.src   = req_src;
                ctl_d.blk   = req_blk;
                ctl_d.wdata = req_wdata;
            end
            ST_EXEC: begin
                ctl_d.st       = ST_IDLE;
                ctl_d.rsp_dst  = ctl_q.src;
                ctl_d.rsp_data = a_data;
                case (ctl_q.kind)
                    RQ_RD: begin
                        if (a_state == DS_E && others != '0) begin
                            ctl_d.st       = ST_WOWN;
                            ctl_d.pend     = a_vec;
                            ctl_d.msg_v    = 1'b1;
                            ctl_d.msg_kind = MK_SHR;
                            ctl_d.msg_vec  = a_vec;
                        end else begin
                            ctl_d.rsp_v = 1'b1;
                            if (a_state != DS_E) begin
                                dir_we      = 1'b1;
                                dir_state_w = DS_S;
                                dir_vec_w   = a_vec | src_bit;
                            end
                        end
                    end
                    RQ_WR: begin
                        if (others != '0) begin
                            ctl_d.st       = (a_state == DS_E) ? ST_WOWN : ST_WINV;
                            ctl_d.pend     = others;
                            ctl_d.msg_v    = 1'b1;
                            ctl_d.msg_kind = (a_state == DS_E) ? MK_TAKE : MK_INV;
                            ctl_d.msg_vec  = others;
                        end else begin
                            ctl_d.rsp_v = 1'b1;
                            dir_we      = 1'b1;
                            dir_state_w = DS_E;
                            dir_vec_w   = src_bit;
                        end
                    end
                    RQ_WB: begin
                        if (a_state == DS_E && a_vec == src_bit) begin
                            dir_we = 1'b1;
                            mem_we = 1'b1;
                            mem_w  = ctl_q.wdata;
                        end
                    end
                    default: ;
                endcase
            end
            ST_WINV: begin
                if (ack_valid && ctl_q.pend[ack_src]) begin
                    pend_left  = ctl_q.pend & ~(NPROC'(1) << ack_src);
                    ctl_d.pend = pend_left;
                    if (pend_left == '0) begin
                        ctl_d.st       = ST_IDLE;
                        ctl_d.rsp_v    = 1'b1;
                        ctl_d.rsp_dst  = ctl_q.src;
                        ctl_d.rsp_data = a_data;
                        dir_we         = 1'b1;
                        dir_state_w    = DS_E;
                        dir_vec_w      = src_bit;
                    end
                end
            end
            ST_WOWN: begin
                if (ack_valid && ctl_q.pend[ack_src]) begin
                    ctl_d.st       = ST_IDLE;
                    ctl_d.pend     = '0;
                    ctl_d.rsp_v    = 1'b1;
                    ctl_d.rsp_dst  = ctl_q.src;
                    ctl_d.rsp_data = ack_data;
                    mem_we         = 1'b1;
                    mem_w          = ack_data;
                    dir_we         = 1'b1;
                    dir_state_w    = (ctl_q.kind == RQ_RD) ? DS_S : DS_E;
                    dir_vec_w      = (ctl_q.kind == RQ_RD) ? (ctl_q.pend | src_bit) : src_bit;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_IDLE;
            ctl_q.kind     <= RQ_NONE;
            ctl_q.msg_kind <= MK_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign msg_valid  = ctl_q.msg_v;
    assign msg_kind   = ctl_q.msg_kind;
    assign msg_vec    = ctl_q.msg_vec;
    assign msg_blk    = ctl_q.blk;
    assign rsp_valid  = ctl_q.rsp_v;
    assign rsp_dst    = ctl_q.rsp_dst;
    assign rsp_data   = ctl_q.rsp_data;
    assign peek_state = b_state;

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_no_rsp_with_msg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && msg_valid));
    assert_recall_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind != MK_INV) |-> ($countones(msg_vec) == 1));
    assert_inval_spares_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_INV) |-> ((msg_vec & src_bit) == '0 && msg_vec != '0));
    assert_entry_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_EXEC) |->
            ((a_state == DS_E && $countones(a_vec) == 1) ||
             (a_state == DS_U && a_vec == '0) ||
             (a_state == DS_S && a_vec != '0)));
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_EXEC && ctl_q.kind == RQ_WB && a_state == DS_E && a_vec == src_bit)
            |=> (ctl_q.st == ST_IDLE && !rsp_valid));
endmodule

// File: tb/sim_coh_home_dir.sv
`timescale 1ns/1ps
module sim_coh_home_dir;
    localparam int NBLK = 8, NP = 3, DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_kind = '0, req_src = '0;
    logic [2:0] req_blk = '0, peek_blk = '0;
    logic [DW-1:0] req_wdata = '0, ack_data = '0, rsp_data, peek_data;
    logic msg_valid, rsp_valid, ack_valid = 1'b0;
    logic [1:0] msg_kind, ack_src = '0, rsp_dst, peek_state;
    logic [NP-1:0] msg_vec, peek_vec;
    logic [2:0] msg_blk;

    int errors = 0, checks = 0;
    logic [1:0]    m_st  [NBLK];
    logic [NP-1:0] m_vec [NBLK];
    logic [DW-1:0] m_mem [NBLK];
    logic [DW-1:0] own_val [NP][NBLK];

    always #2 clk = ~clk;

    coh_home_dir u0 (.*);

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int owner_of(input logic [NP-1:0] v);
        for (int i = 0; i < NP; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic peek_check(input string req, input int b);
        peek_blk = 3'(b);
        #1;
        chk(req, "state", 32'(peek_state), 32'(m_st[b]));
        chk(req, "presence", 32'(peek_vec), 32'(m_vec[b]));
        chk(req, "memory", 32'(peek_data), 32'(m_mem[b]));
    endtask

    task automatic txn(input int kind, input int src, input int b);
        logic [NP-1:0] bit_s, others, exp_mvec, ackset;
        int exp_mk, exp_nmsg, exp_rsp, nmsg, guard, o, p;
        logic [DW-1:0] exp_data;
        string tag;
        bit_s = NP'(1) << src;
        others = m_vec[b] & ~bit_s;
        exp_mk = 0; exp_mvec = '0; exp_rsp = 0; exp_data = m_mem[b];
        o = owner_of(m_vec[b]);
        tag = "R2";
        if (kind == 0) begin
            exp_rsp = 1;
            if (m_st[b] == 2 && others != 0) begin
                tag = "R3"; exp_mk = 2; exp_mvec = m_vec[b];
                m_mem[b] = own_val[o][b]; exp_data = m_mem[b];
                m_st[b] = 1; m_vec[b] = m_vec[b] | bit_s;
            end else if (m_st[b] != 2) begin
                m_st[b] = 1; m_vec[b] = m_vec[b] | bit_s;
            end
        end else if (kind == 1) begin
            exp_rsp = 1;
            if (m_st[b] == 0) tag = "R7";
            else if (m_st[b] == 1 && others == 0) tag = "R5";
            else if (m_st[b] == 1) begin tag = "R4"; exp_mk = 1; exp_mvec = others; end
            else if (others != 0) begin
                tag = "R6"; exp_mk = 3; exp_mvec = others;
                m_mem[b] = own_val[o][b]; exp_data = m_mem[b];
            end
            m_st[b] = 2; m_vec[b] = bit_s;
        end else begin
            tag = "R8";
            if (m_st[b] == 2 && m_vec[b] == bit_s) begin
                m_mem[b] = own_val[src][b]; m_st[b] = 0; m_vec[b] = '0;
            end
        end
        exp_nmsg = (exp_mk != 0) ? 1 : 0;

        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_src = 2'(src); req_blk = 3'(b);
        req_wdata = own_val[src][b];
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "ready after accept", 32'(req_ready), 0);
        nmsg = 0; ackset = '0; guard = 0;
        while (!req_ready && guard < 50) begin
            if (rsp_valid) chk("R9", "early reply", 1, 0);
            if (msg_valid) begin
                nmsg++;
                chk(tag, "message kind", 32'(msg_kind), 32'(exp_mk));
                chk(tag, "message vector", 32'(msg_vec), 32'(exp_mvec));
                chk(tag, "message block", 32'(msg_blk), 32'(b));
                ackset = msg_vec;
            end
            if (ackset != 0) begin
                p = owner_of(ackset);
                ack_valid = 1'b1; ack_src = 2'(p); ack_data = own_val[p][b];
                ackset[p] = 1'b0;
            end else ack_valid = 1'b0;
            @(negedge clk);
            guard++;
        end
        ack_valid = 1'b0;
        chk(tag, "message count", 32'(nmsg), 32'(exp_nmsg));
        chk(tag, "reply present", 32'(rsp_valid), 32'(exp_rsp));
        if (exp_rsp != 0) begin
            chk(tag, "reply data", 32'(rsp_data), 32'(exp_data));
            chk(tag, "reply target", 32'(rsp_dst), 32'(src));
        end
        if (kind == 1) own_val[src][b] = 16'($urandom);
        peek_check(tag, b);
        chk("R10", "entry shape", 32'((m_st[b] == 2 && $countones(peek_vec) == 1) ||
            (m_st[b] == 0 && peek_vec == 0) || (m_st[b] == 1 && peek_vec != 0)), 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < NBLK; b++) begin
            m_st[b] = 0; m_vec[b] = '0; m_mem[b] = '0;
            for (int p = 0; p < NP; p++) own_val[p][b] = 16'($urandom);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready", 32'(req_ready), 1);
        for (int b = 0; b < NBLK; b++) peek_check("R1", b);

        txn(1, 0, 2);          // R7: write to uncached
        txn(2, 0, 2);          // R8: owner flush
        txn(0, 0, 1);          // R2: read uncached
        txn(0, 2, 1);          // R2: read shared
        txn(0, 1, 1);
        txn(1, 1, 1);          // R4: invalidate 0 and 2
        txn(2, 2, 1);          // R8: non-owner write-back ignored
        txn(1, 2, 1);          // R6: take away from 1
        txn(0, 0, 1);          // R3: downgrade owner 2
        txn(0, 0, 3);
        txn(1, 0, 3);          // R5: sole sharer upgrade
        txn(2, 0, 1);          // R8: shared block write-back ignored

        for (int i = 0; i < 200; i++) begin
            int k, s, b;
            k = int'($urandom % 3);
            s = int'($urandom % NP);
            b = int'($urandom % NBLK);
            if (k == 2 && m_st[b] == 2 && ($urandom % 10) < 7) s = owner_of(m_vec[b]);
            txn(k, s, b);
        end
        for (int b = 0; b < NBLK; b++) peek_check("R2", b);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule